// File: doc/BRIEF.md
# Voted Power Domain Controller

This block lets several requesters, an application processor and a number of remote processors, share control of a bank of power domains without any of them switching a domain directly. Each requester posts a power-on or power-off vote for one or more domains by writing a bit mask to a register on a simple bus. The bus carries the requester's identifier with every write. The controller keeps one vote bit per requester and domain. It drives each domain's power switch from the OR of that domain's votes. It then runs a short per-domain sequence that waits for the switch acknowledge, and after a power-off it also waits a settling period.

Software sees each domain at the same bit index in six registers. The vote-on register reads 1 when idle, drops to 0 for one cycle after a vote is taken, and reads 1 again once processing has begun. The vote-off register reads 1 from the write until processing starts. An idle register tells software when a domain can take a new command. An enabled register holds the OR of the votes. Two busy registers, one per direction, stay high while a sequence runs. A write to a domain that is not idle is dropped for that domain.

Top module: `vote_pd_ctrl`

## Requirements
- R1: After reset, word 2 (idle) reads all ones, word 0 (vote-on) reads all ones, and words 1, 3, 4 and 5 and `pwr_en` are all zero.
- R2: Register words are 0 vote-on, 1 vote-off, 2 idle, 3 enabled, 4 on-busy, 5 off-busy, and domain d is bit d in each. Reads of words 6 and 7 return zero. Writes to words 2 to 7 change nothing.
- R3: A vote-on write to an idle domain makes its vote-on bit read 0, its idle bit 0 and its on-busy bit 1 in the following cycle. One cycle later the vote-on bit reads 1 again.
- R4: A power-on sequence ends, with idle set and on-busy clear, in the cycle after the one in which `pwr_ack` matches the enabled bit. With a 3-cycle acknowledge delay the idle bit returns 4 cycles after the write.
- R5: A vote-off write to an idle domain makes its vote-off bit and off-busy bit read 1 and its idle bit read 0 in the following cycle. One cycle later the vote-off bit reads 0 while off-busy stays 1.
- R6: After processing of a vote-off begins, idle stays low for at least STAB_CYCLES cycles and until the acknowledge matches. With the default of 8 the idle bit returns 10 cycles after the write.
- R7: A domain's enabled bit and `pwr_en` bit are the OR of all requesters' votes. A vote-off from one requester removes only that requester's vote.
- R8: A vote-on or vote-off write to a domain whose idle bit is 0 is ignored for that domain: no vote changes and no status bit changes.
- R9: Domains sequence independently, and one write may start several domains at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register word select |
| bus_wdata | input | NDOM | Write mask, one bit per domain |
| bus_rid | input | RIDW | Identifier of the writing requester |
| bus_rdata | output | NDOM | Read data for the selected word, combinational |
| pwr_en | output | NDOM | Power switch enable per domain |
| pwr_ack | input | NDOM | Power-good acknowledge per domain |

## Verification
The bench targets the one-cycle dip of the vote-on bit. A design that never dipped, or dipped for longer, would fail the readbacks on either side of it. It measures the exact cycles to idle after power-on and power-off. A design missing the settling wait would return idle too early, and one that skipped the acknowledge would return it before the switch settled. Two requesters share a domain, so a design that cleared the whole domain on one vote-off would drop `pwr_en` too soon. Writes are also posted while a domain is busy. A design that accepted them would either show an off request or keep a stray vote, which later holds the domain on.

// File: rtl/vote_pd_ctrl.sv
module vote_pd_ctrl #(
  parameter int NDOM        = 4,
  parameter int NREQ        = 2,
  parameter int STAB_CYCLES = 8,
  parameter int RIDW        = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [2:0]      bus_addr,
  input  logic [NDOM-1:0] bus_wdata,
  input  logic [RIDW-1:0] bus_rid,
  output logic [NDOM-1:0] bus_rdata,
  output logic [NDOM-1:0] pwr_en,
  input  logic [NDOM-1:0] pwr_ack
);
  localparam logic [2:0] W_SET  = 3'd0;
  localparam logic [2:0] W_CLR  = 3'd1;
  localparam logic [2:0] W_DONE = 3'd2;
  localparam logic [2:0] W_EN   = 3'd3;
  localparam logic [2:0] W_SSTA = 3'd4;
  localparam logic [2:0] W_CSTA = 3'd5;
  localparam int CW = $clog2(STAB_CYCLES + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_ON_ACC, S_ON_RUN, S_OFF_ACC, S_OFF_STAB, S_OFF_RUN
  } seq_t;

  logic [NDOM-1:0] vote [NREQ];
  logic [NDOM-1:0] en_v, done_v, ssta_v, csta_v, set_rd, clr_rd;
  logic [NDOM-1:0] set_hit, clr_hit;

  assign set_hit = (bus_wr && bus_addr == W_SET) ? (bus_wdata & done_v) : '0;
  assign clr_hit = (bus_wr && bus_addr == W_CLR) ? (bus_wdata & done_v) : '0;

  for (genvar r = 0; r < NREQ; r++) begin : g_req
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        vote[r] <= '0;
      else if (bus_rid == RIDW'(r))
        vote[r] <= (vote[r] | set_hit) & ~clr_hit;
    end
  end

  always_comb begin
    en_v = '0;
    for (int r = 0; r < NREQ; r++) en_v = en_v | vote[r];
  end

  assign pwr_en = en_v;

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    seq_t          st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          S_IDLE:    if (set_hit[d]) st <= S_ON_ACC;
                     else if (clr_hit[d]) st <= S_OFF_ACC;
          S_ON_ACC:  st <= S_ON_RUN;
          S_ON_RUN:  if (pwr_ack[d] == en_v[d]) st <= S_IDLE;
          S_OFF_ACC: begin
            st  <= S_OFF_STAB;
            cnt <= '0;
          end
          S_OFF_STAB: if (cnt == CW'(STAB_CYCLES - 1)) st <= S_OFF_RUN;
                      else cnt <= cnt + 1'b1;
          S_OFF_RUN: if (pwr_ack[d] == en_v[d]) st <= S_IDLE;
          default:   st <= S_IDLE;
        endcase
      end
    end

    assign done_v[d] = (st == S_IDLE);
    assign ssta_v[d] = (st == S_ON_ACC) || (st == S_ON_RUN);
    assign csta_v[d] = (st == S_OFF_ACC) || (st == S_OFF_STAB) || (st == S_OFF_RUN);
    assign set_rd[d] = (st != S_ON_ACC);
    assign clr_rd[d] = (st == S_OFF_ACC);
  end

  always_comb begin
    case (bus_addr)
      W_SET:   bus_rdata = set_rd;
      W_CLR:   bus_rdata = clr_rd;
      W_DONE:  bus_rdata = done_v;
      W_EN:    bus_rdata = en_v;
      W_SSTA:  bus_rdata = ssta_v;
      W_CSTA:  bus_rdata = csta_v;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/vote_pd_ctrl_chk.sv
module vote_pd_ctrl_chk #(
  parameter int NDOM = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NDOM-1:0] pwr_en,
  input logic [NDOM-1:0] pwr_ack,
  input logic [NDOM-1:0] done_v,
  input logic [NDOM-1:0] en_v,
  input logic [NDOM-1:0] ssta_v,
  input logic [NDOM-1:0] csta_v,
  input logic [NDOM-1:0] set_rd,
  input logic [NDOM-1:0] clr_rd
);
  assert_set_dip_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~$past(set_rd) & ~set_rd) == '0));

  assert_clr_then_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_rd) & (clr_rd | ~csta_v)) == '0));

  assert_busy_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ssta_v & csta_v) == '0);

  assert_finish_needs_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(ssta_v | csta_v) & ~(ssta_v | csta_v)) & $past(pwr_ack ^ pwr_en)) == '0));

  assert_busy_votes_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((en_v ^ $past(en_v)) & ~$past(done_v)) == '0));
endmodule

bind vote_pd_ctrl vote_pd_ctrl_chk #(.NDOM(NDOM)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .pwr_ack(pwr_ack),
  .done_v(done_v), .en_v(en_v), .ssta_v(ssta_v), .csta_v(csta_v),
  .set_rd(set_rd), .clr_rd(clr_rd)
);

// File: tb/vote_pd_ctrl_bench.sv
module vote_pd_ctrl_bench;
  localparam int NDOM = 4;
  localparam int STAB = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0;
  logic [2:0]      bus_addr = '0;
  logic [NDOM-1:0] bus_wdata = '0;
  logic [0:0]      bus_rid = '0;
  logic [NDOM-1:0] bus_rdata, pwr_en, pwr_ack;
  logic [NDOM-1:0] ack_d1, ack_d2, ack_d3;

  int total = 0;
  int fails = 0;
  int exp_q[$];
  string tag_q[$];
  logic [NDOM-1:0] en_prev;

  always #10 clk = ~clk;

  vote_pd_ctrl #(.NDOM(NDOM), .NREQ(2), .STAB_CYCLES(STAB)) u_vote_pd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rid(bus_rid), .bus_rdata(bus_rdata),
    .pwr_en(pwr_en), .pwr_ack(pwr_ack)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_d1 <= '0; ack_d2 <= '0; ack_d3 <= '0;
    end else begin
      ack_d1 <= pwr_en; ack_d2 <= ack_d1; ack_d3 <= ack_d2;
    end
  end
  assign pwr_ack = ack_d3;

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic expect_edge(input int d, input int v, input string tag);
    exp_q.push_back(d * 2 + v);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (!rst_n) en_prev <= '0;
    else begin
      for (int d = 0; d < NDOM; d++) begin
        if (pwr_en[d] != en_prev[d]) begin
          if (exp_q.size() == 0) chk("R7 unexpected pwr_en change", d * 2 + int'(pwr_en[d]), -1);
          else chk(tag_q.pop_front(), d * 2 + int'(pwr_en[d]), exp_q.pop_front());
        end
      end
      en_prev <= pwr_en;
    end
  end

  task automatic rd(input logic [2:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic wr(input logic [2:0] a, input logic [NDOM-1:0] m, input logic r);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = m; bus_rid = r;
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_done(input int d, input int k0, output int k);
    int v;
    k = k0;
    forever begin
      rd(3'd2, v);
      if (v[d] || k > 1000) break;
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int v, k;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(3'd0, v); chk("R1 vote-on reset", v, 4'hF);
    rd(3'd1, v); chk("R1 vote-off reset", v, 0);
    rd(3'd2, v); chk("R1 idle reset", v, 4'hF);
    rd(3'd3, v); chk("R1 enabled reset", v, 0);
    rd(3'd4, v); chk("R1 on-busy reset", v, 0);
    rd(3'd5, v); chk("R1 off-busy reset", v, 0);
    chk("R1 pwr_en reset", int'(pwr_en), 0);
    rd(3'd6, v); chk("R2 unused word reads zero", v, 0);

    expect_edge(0, 1, "R4 domain0 on");
    wr(3'd0, 4'b0001, 1'b0);
    rd(3'd0, v); chk("R3 vote-on dips", v, 4'hE);
    rd(3'd4, v); chk("R3 on-busy set", v, 4'h1);
    rd(3'd2, v); chk("R3 idle low", v, 4'hE);
    @(negedge clk);
    rd(3'd0, v); chk("R3 vote-on back to 1", v, 4'hF);
    wait_done(0, 1, k); chk("R4 on cycles", k, 4);
    rd(3'd4, v); chk("R4 on-busy clear", v, 0);
    rd(3'd3, v); chk("R4 enabled", v, 4'h1);

    expect_edge(0, 0, "R6 domain0 off");
    wr(3'd1, 4'b0001, 1'b0);
    rd(3'd1, v); chk("R5 vote-off reads 1", v, 4'h1);
    rd(3'd5, v); chk("R5 off-busy set", v, 4'h1);
    rd(3'd2, v); chk("R5 idle low", v, 4'hE);
    @(negedge clk);
    rd(3'd1, v); chk("R5 vote-off clears", v, 0);
    rd(3'd5, v); chk("R5 off-busy held", v, 4'h1);
    wait_done(0, 1, k); chk("R6 off cycles", k, STAB + 2);
    rd(3'd5, v); chk("R6 off-busy clear", v, 0);

    expect_edge(1, 1, "R7 domain1 on");
    wr(3'd0, 4'b0010, 1'b0);
    wait_done(1, 0, k); chk("R4 domain1 on cycles", k, 4);
    wr(3'd0, 4'b0010, 1'b1);
    wait_done(1, 0, k); chk("R7 second vote cycles", k, 2);
    wr(3'd1, 4'b0010, 1'b0);
    rd(3'd3, v); chk("R7 enabled held by other vote", v, 4'h2);
    wait_done(1, 0, k); chk("R7 partial off cycles", k, STAB + 2);
    chk("R7 pwr_en held", int'(pwr_en), 4'h2);
    expect_edge(1, 0, "R7 domain1 off");
    wr(3'd1, 4'b0010, 1'b1);
    rd(3'd3, v); chk("R7 enabled after last vote off", v, 0);
    wait_done(1, 0, k); chk("R7 final off cycles", k, STAB + 2);

    expect_edge(2, 1, "R8 domain2 on");
    wr(3'd0, 4'b0100, 1'b0);
    wr(3'd1, 4'b0100, 1'b0);
    rd(3'd1, v); chk("R8 busy vote-off ignored", v, 0);
    rd(3'd5, v); chk("R8 off-busy unchanged", v, 0);
    wr(3'd0, 4'b0100, 1'b1);
    wait_done(2, 2, k); chk("R8 on cycles unchanged", k, 4);
    rd(3'd3, v); chk("R8 enabled kept", v, 4'h4);
    expect_edge(2, 0, "R8 no stray vote");
    wr(3'd1, 4'b0100, 1'b0);
    wait_done(2, 0, k);
    chk("R8 domain2 off after one vote-off", int'(pwr_en), 0);
    wr(3'd2, 4'b0000, 1'b0);
    rd(3'd2, v); chk("R2 idle word not writable", v, 4'hF);

    expect_edge(1, 1, "R9 domain1 on");
    expect_edge(3, 1, "R9 domain3 on");
    wr(3'd0, 4'b1010, 1'b1);
    wait_done(1, 0, k); chk("R9 domain1 cycles", k, 4);
    wait_done(3, k, k); chk("R9 domain3 cycles", k, 4);
    rd(3'd3, v); chk("R9 both enabled", v, 4'hA);
    expect_edge(1, 0, "R9 domain1 off");
    wr(3'd1, 4'b0010, 1'b1);
    rd(3'd2, v); chk("R9 domain3 stays idle", v, 4'hD);
    wait_done(1, 0, k);
    chk("R9 domain3 still on", int'(pwr_en), 4'h8);

    repeat (2) @(negedge clk);
    chk("R9 all expected edges seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule